// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits next to a simple memory subordinate and watches its read-address and write-address channels. It never drives those channels. It only samples a transfer in the cycle where valid and ready are both high, together with the transfer's lock bit, ID, start address, beat count and beat size. From these it keeps one reservation per transaction ID. Each reservation holds a valid flag, a start address and a total byte length.

An exclusive read arms the reservation for its ID. Any write that is allowed to reach memory clears every reservation whose byte range it overlaps. An exclusive write succeeds only when its own ID still holds a reservation with exactly the same start address and byte length.

For every accepted read and every accepted write, the block gives a verdict one clock later. The verdict is a pulse carrying the ID and the response code, which the subordinate copies onto RRESP or BRESP. For writes it also raises an inhibit flag that tells the memory to drop all write strobes of a failed exclusive store.

Back-pressure rules: the block adds no stall of its own. It counts a transfer only when valid and ready are high together, so a stalled request (valid without ready) has no effect. The verdict pulses have no ready. The response path must capture them in the cycle they appear.

Top module: `axi_excl_monitor`

## Requirements
- R1: A read or write is recognised only in a cycle with both valid and ready high. Its verdict pulse appears exactly one cycle later, and a stalled request produces no pulse and changes no reservation.
- R2: An exclusive read (lock bit 1) whose total length (len+1)<<size is at most MAX_EXCL_BYTES returns code 2'b01 (EXOKAY) and arms the reservation of its ID with that start address and length.
- R3: An exclusive write (lock bit 1) succeeds when its ID holds a valid reservation with the same start address and the same total byte length. The verdict is code 2'b01 with inhibit low, and the write clears its own reservation.
- R4: An exclusive write that does not meet R3 fails. The verdict is code 2'b00 (OKAY) with inhibit high.
- R5: A write that reaches memory (normal, or successful exclusive) clears the reservation of every ID whose byte range [start, start+length) overlaps its own. A range that only touches the end of another does not overlap.
- R6: A normal write (lock bit 0) always gets code 2'b00 with inhibit low and never arms a reservation.
- R7: A new exclusive read from an ID replaces that ID's earlier reservation.
- R8: A normal read gets code 2'b00 and neither arms nor clears any reservation.
- R9: An exclusive read longer than MAX_EXCL_BYTES gets code 2'b00 and leaves its ID without a reservation.
- R10: When a read and a write are accepted in the same cycle, the write is judged against the reservations held before that cycle. A reservation armed by the read in that cycle survives the write.
- R11: A failed exclusive write clears no reservation.
- R12: A synchronous active-low reset clears all reservations and all verdict outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ar_valid | input | 1 | Read-address valid (observed) |
| ar_ready | input | 1 | Read-address ready (observed) |
| ar_id | input | ID_W | Read transaction ID |
| ar_addr | input | ADDR_W | Read start address |
| ar_len | input | 8 | Read beats minus one |
| ar_size | input | 3 | Read log2 bytes per beat |
| ar_lock | input | 1 | Read lock: 0 normal, 1 exclusive |
| aw_valid | input | 1 | Write-address valid (observed) |
| aw_ready | input | 1 | Write-address ready (observed) |
| aw_id | input | ID_W | Write transaction ID |
| aw_addr | input | ADDR_W | Write start address |
| aw_len | input | 8 | Write beats minus one |
| aw_size | input | 3 | Write log2 bytes per beat |
| aw_lock | input | 1 | Write lock: 0 normal, 1 exclusive |
| rd_rsp_vld | output | 1 | Read verdict pulse |
| rd_rsp_id | output | ID_W | ID of the judged read |
| rd_rsp_code | output | 2 | Read response code (00 OKAY, 01 EXOKAY) |
| wr_rsp_vld | output | 1 | Write verdict pulse |
| wr_rsp_id | output | ID_W | ID of the judged write |
| wr_rsp_code | output | 2 | Write response code (00 OKAY, 01 EXOKAY) |
| wr_inhibit | output | 1 | Failed exclusive write: suppress all strobes |

## Verification
The bench builds the block with its defaults: ID_W=2 (four reservation slots), ADDR_W=32 and MAX_EXCL_BYTES=128. Four slots are enough to hold several live reservations at once. This lets the bench show that a failed store leaves other IDs alone and that only overlapping ranges are cleared, including the edge case where a range merely touches another. The 128-byte limit makes it possible to issue a 256-byte exclusive read and observe it refused.

// File: rtl/xm_pkg.sv
package xm_pkg;
  typedef enum logic [1:0] {
    RSP_OKAY   = 2'b00,
    RSP_EXOKAY = 2'b01
  } rsp_code_e;

  localparam int LEN_W  = 8;
  localparam int SIZE_W = 3;
endpackage

// File: rtl/xm_span.sv
// Total byte length of a burst: (beats) << log2(bytes per beat).
module xm_span #(
  parameter int LEN_W   = 8,
  parameter int SIZE_W  = 3,
  parameter int BYTES_W = 16
) (
  input  logic [LEN_W-1:0]   len,
  input  logic [SIZE_W-1:0]  size,
  output logic [BYTES_W-1:0] bytes
);
  logic [BYTES_W-1:0] beats;

  always_comb begin
    beats = BYTES_W'(len) + BYTES_W'(1);
    bytes = beats << size;
  end
endmodule

// File: rtl/xm_overlap.sv
// Half-open range intersection test, computed one bit wider than the address.
module xm_overlap #(
  parameter int ADDR_W  = 32,
  parameter int BYTES_W = 16
) (
  input  logic [ADDR_W-1:0]  a_addr,
  input  logic [BYTES_W-1:0] a_bytes,
  input  logic [ADDR_W-1:0]  b_addr,
  input  logic [BYTES_W-1:0] b_bytes,
  output logic               hit
);
  localparam int EW = ADDR_W + 1;

  logic [EW-1:0] a_lo, a_hi, b_lo, b_hi;

  always_comb begin
    a_lo = EW'(a_addr);
    b_lo = EW'(b_addr);
    a_hi = a_lo + EW'(a_bytes);
    b_hi = b_lo + EW'(b_bytes);
    hit  = (a_lo < b_hi) && (b_lo < a_hi);
  end
endmodule

// File: rtl/xm_resv_slot.sv
// One reservation: valid flag, start address, byte length. Arm beats clear.
module xm_resv_slot #(
  parameter int ADDR_W  = 32,
  parameter int BYTES_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic [ADDR_W-1:0]  arm_addr,
  input  logic [BYTES_W-1:0] arm_bytes,
  input  logic               kill,
  output logic               vld,
  output logic [ADDR_W-1:0]  addr,
  output logic [BYTES_W-1:0] bytes
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld   <= 1'b0;
      addr  <= '0;
      bytes <= '0;
    end else if (arm) begin
      vld   <= 1'b1;
      addr  <= arm_addr;
      bytes <= arm_bytes;
    end else if (kill) begin
      vld   <= 1'b0;
    end
  end

  AST_ARM_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> vld); // R2
  AST_KILL_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (kill && !arm) |=> !vld); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill && !arm) |=> $stable(vld)); // R11
endmodule

// File: rtl/xm_resp_regs.sv
// Registers the read and write verdicts into one-cycle pulses.
module xm_resp_regs #(
  parameter int ID_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_fire,
  input  logic [ID_W-1:0] rd_id,
  input  logic [1:0]      rd_code,
  input  logic            wr_fire,
  input  logic [ID_W-1:0] wr_id,
  input  logic [1:0]      wr_code,
  input  logic            wr_block,
  output logic            rd_rsp_vld,
  output logic [ID_W-1:0] rd_rsp_id,
  output logic [1:0]      rd_rsp_code,
  output logic            wr_rsp_vld,
  output logic [ID_W-1:0] wr_rsp_id,
  output logic [1:0]      wr_rsp_code,
  output logic            wr_inhibit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_rsp_vld  <= 1'b0;
      rd_rsp_id   <= '0;
      rd_rsp_code <= 2'b00;
      wr_rsp_vld  <= 1'b0;
      wr_rsp_id   <= '0;
      wr_rsp_code <= 2'b00;
      wr_inhibit  <= 1'b0;
    end else begin
      rd_rsp_vld  <= rd_fire;
      rd_rsp_id   <= rd_fire ? rd_id : '0;
      rd_rsp_code <= rd_fire ? rd_code : 2'b00;
      wr_rsp_vld  <= wr_fire;
      wr_rsp_id   <= wr_fire ? wr_id : '0;
      wr_rsp_code <= wr_fire ? wr_code : 2'b00;
      wr_inhibit  <= wr_fire & wr_block;
    end
  end
endmodule

// File: rtl/axi_excl_monitor.sv
module axi_excl_monitor
  import xm_pkg::*;
#(
  parameter int ID_W           = 2,
  parameter int ADDR_W         = 32,
  parameter int BYTES_W        = 16,
  parameter int MAX_EXCL_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [7:0]        ar_len,
  input  logic [2:0]        ar_size,
  input  logic              ar_lock,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [7:0]        aw_len,
  input  logic [2:0]        aw_size,
  input  logic              aw_lock,
  output logic              rd_rsp_vld,
  output logic [ID_W-1:0]   rd_rsp_id,
  output logic [1:0]        rd_rsp_code,
  output logic              wr_rsp_vld,
  output logic [ID_W-1:0]   wr_rsp_id,
  output logic [1:0]        wr_rsp_code,
  output logic              wr_inhibit
);
  localparam int NUM_IDS = 1 << ID_W;

  logic               ar_fire, aw_fire;
  logic [BYTES_W-1:0] rd_bytes, wr_bytes;
  logic               rd_fits, rd_arm, rd_refuse;
  logic               own_match, wr_commit, wr_excl_ok, wr_excl_bad;
  rsp_code_e          rd_code, wr_code;

  logic               slot_vld   [NUM_IDS];
  logic [ADDR_W-1:0]  slot_addr  [NUM_IDS];
  logic [BYTES_W-1:0] slot_bytes [NUM_IDS];
  logic               slot_hit   [NUM_IDS];
  logic               slot_arm   [NUM_IDS];
  logic               slot_kill  [NUM_IDS];

  assign ar_fire = ar_valid & ar_ready;
  assign aw_fire = aw_valid & aw_ready;

  xm_span #(.LEN_W(LEN_W), .SIZE_W(SIZE_W), .BYTES_W(BYTES_W)) u_rd_span (
    .len(ar_len), .size(ar_size), .bytes(rd_bytes));
  xm_span #(.LEN_W(LEN_W), .SIZE_W(SIZE_W), .BYTES_W(BYTES_W)) u_wr_span (
    .len(aw_len), .size(aw_size), .bytes(wr_bytes));

  always_comb begin
    rd_fits   = (rd_bytes <= BYTES_W'(MAX_EXCL_BYTES));
    rd_arm    = ar_fire & ar_lock & rd_fits;
    rd_refuse = ar_fire & ar_lock & ~rd_fits;
    rd_code   = rd_arm ? RSP_EXOKAY : RSP_OKAY;

    own_match = slot_vld[aw_id] && (slot_addr[aw_id] == aw_addr) &&
                (slot_bytes[aw_id] == wr_bytes);
    wr_excl_ok  = aw_fire & aw_lock & own_match;
    wr_excl_bad = aw_fire & aw_lock & ~own_match;
    wr_commit   = aw_fire & (~aw_lock | own_match);
    wr_code     = wr_excl_ok ? RSP_EXOKAY : RSP_OKAY;
  end

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_slot
    xm_overlap #(.ADDR_W(ADDR_W), .BYTES_W(BYTES_W)) u_ovl (
      .a_addr (slot_addr[i]),
      .a_bytes(slot_bytes[i]),
      .b_addr (aw_addr),
      .b_bytes(wr_bytes),
      .hit    (slot_hit[i])
    );

    always_comb begin
      slot_arm[i]  = rd_arm && (ar_id == ID_W'(i));
      slot_kill[i] = (wr_commit && slot_hit[i]) ||
                     (rd_refuse && (ar_id == ID_W'(i)));
    end

    xm_resv_slot #(.ADDR_W(ADDR_W), .BYTES_W(BYTES_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (slot_arm[i]),
      .arm_addr (ar_addr),
      .arm_bytes(rd_bytes),
      .kill     (slot_kill[i]),
      .vld      (slot_vld[i]),
      .addr     (slot_addr[i]),
      .bytes    (slot_bytes[i])
    );
  end

  xm_resp_regs #(.ID_W(ID_W)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_fire    (ar_fire),
    .rd_id      (ar_id),
    .rd_code    (rd_code),
    .wr_fire    (aw_fire),
    .wr_id      (aw_id),
    .wr_code    (wr_code),
    .wr_block   (wr_excl_bad),
    .rd_rsp_vld (rd_rsp_vld),
    .rd_rsp_id  (rd_rsp_id),
    .rd_rsp_code(rd_rsp_code),
    .wr_rsp_vld (wr_rsp_vld),
    .wr_rsp_id  (wr_rsp_id),
    .wr_rsp_code(wr_rsp_code),
    .wr_inhibit (wr_inhibit)
  );

  AST_WR_VERDICT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    aw_fire |=> wr_rsp_vld); // R1
  AST_WR_QUIET_WITHOUT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !aw_fire |=> !wr_rsp_vld); // R1
  AST_RD_VERDICT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ar_fire |=> rd_rsp_vld); // R1
  AST_INHIBIT_IS_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rsp_vld && wr_inhibit) |-> (wr_rsp_code == 2'b00)); // R4
  AST_WR_EXOKAY_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rsp_vld && wr_rsp_code == 2'b01) |-> $past(aw_lock)); // R6
  AST_RD_EXOKAY_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_vld && rd_rsp_code == 2'b01) |-> $past(ar_lock)); // R8
  AST_NORMAL_WR_NOT_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_fire && !aw_lock) |=> !wr_inhibit); // R6
endmodule

// File: tb/axi_excl_monitor_tb_top.sv
module axi_excl_monitor_tb_top;
  localparam int ID_W = 2;
  localparam int AW   = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ar_valid = 0, ar_ready = 0, ar_lock = 0;
  logic [ID_W-1:0] ar_id = '0;
  logic [AW-1:0] ar_addr = '0;
  logic [7:0]    ar_len = '0;
  logic [2:0]    ar_size = '0;
  logic          aw_valid = 0, aw_ready = 0, aw_lock = 0;
  logic [ID_W-1:0] aw_id = '0;
  logic [AW-1:0] aw_addr = '0;
  logic [7:0]    aw_len = '0;
  logic [2:0]    aw_size = '0;
  logic          rd_rsp_vld, wr_rsp_vld, wr_inhibit;
  logic [ID_W-1:0] rd_rsp_id, wr_rsp_id;
  logic [1:0]    rd_rsp_code, wr_rsp_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  localparam logic [1:0] OKAY = 2'b00, EXOK = 2'b01;
  localparam logic [AW-1:0] A = 32'h1000, B = 32'h2000;

  always #2 clk = ~clk;

  axi_excl_monitor dut_i (
    .clk(clk), .rst_n(rst_n),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_addr(ar_addr),
    .ar_len(ar_len), .ar_size(ar_size), .ar_lock(ar_lock),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_addr(aw_addr),
    .aw_len(aw_len), .aw_size(aw_size), .aw_lock(aw_lock),
    .rd_rsp_vld(rd_rsp_vld), .rd_rsp_id(rd_rsp_id), .rd_rsp_code(rd_rsp_code),
    .wr_rsp_vld(wr_rsp_vld), .wr_rsp_id(wr_rsp_id), .wr_rsp_code(wr_rsp_code),
    .wr_inhibit(wr_inhibit)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_rd(input logic [ID_W-1:0] id, input logic [AW-1:0] a,
                        input logic [7:0] l, input logic [2:0] s, input logic lk);
    ar_id = id; ar_addr = a; ar_len = l; ar_size = s; ar_lock = lk;
    ar_valid = 1; ar_ready = 1;
  endtask

  task automatic set_wr(input logic [ID_W-1:0] id, input logic [AW-1:0] a,
                        input logic [7:0] l, input logic [2:0] s, input logic lk);
    aw_id = id; aw_addr = a; aw_len = l; aw_size = s; aw_lock = lk;
    aw_valid = 1; aw_ready = 1;
  endtask

  // Each op: drive at negedge, captured at posedge, verdict sampled next negedge.
  task automatic rd(input logic [ID_W-1:0] id, input logic [AW-1:0] a,
                    input logic [7:0] l, input logic [2:0] s, input logic lk);
    @(negedge clk); set_rd(id, a, l, s, lk);
    @(negedge clk); ar_valid = 0; ar_ready = 0;
  endtask

  task automatic wr(input logic [ID_W-1:0] id, input logic [AW-1:0] a,
                    input logic [7:0] l, input logic [2:0] s, input logic lk);
    @(negedge clk); set_wr(id, a, l, s, lk);
    @(negedge clk); aw_valid = 0; aw_ready = 0;
  endtask

  task automatic expect_wr(input string req, input logic [ID_W-1:0] id,
                           input logic [1:0] code, input logic inh);
    check({req, " wr vld"}, wr_rsp_vld, 1);
    check({req, " wr id"}, wr_rsp_id, id);
    check({req, " wr code"}, wr_rsp_code, code);
    check({req, " inhibit"}, wr_inhibit, inh);
  endtask

  task automatic expect_rd(input string req, input logic [ID_W-1:0] id,
                           input logic [1:0] code);
    check({req, " rd vld"}, rd_rsp_vld, 1);
    check({req, " rd id"}, rd_rsp_id, id);
    check({req, " rd code"}, rd_rsp_code, code);
  endtask

  task automatic t_reset_state();
    check("R12 rd vld after reset", rd_rsp_vld, 0);
    check("R12 wr vld after reset", wr_rsp_vld, 0);
    check("R12 inhibit after reset", wr_inhibit, 0);
  endtask

  task automatic t_basic_pair();
    rd(0, A, 3, 2, 1); expect_rd("R2", 0, EXOK);
    wr(0, A, 3, 2, 1); expect_wr("R3", 0, EXOK, 0);
    wr(0, A, 3, 2, 1); expect_wr("R3 own entry cleared", 0, OKAY, 1);
    wr(1, A, 3, 2, 1); expect_wr("R4 never armed", 1, OKAY, 1);
    rd(1, A, 3, 2, 1); expect_rd("R2 id1", 1, EXOK);
    wr(1, A, 1, 2, 1); expect_wr("R4 length mismatch", 1, OKAY, 1);
  endtask

  task automatic t_overlap();
    rd(0, A, 3, 2, 1); expect_rd("R2", 0, EXOK);
    wr(2, 32'h0FF0, 3, 2, 0); expect_wr("R6 normal", 2, OKAY, 0);
    wr(0, A, 3, 2, 1); expect_wr("R5 touching range keeps", 0, EXOK, 0);
    rd(0, A, 3, 2, 1); expect_rd("R2", 0, EXOK);
    wr(2, 32'h100C, 0, 2, 0); expect_wr("R6 normal", 2, OKAY, 0);
    wr(0, A, 3, 2, 1); expect_wr("R5 overlap clears", 0, OKAY, 1);
  endtask

  task automatic t_replace();
    rd(1, A, 3, 2, 1); rd(1, B, 3, 2, 1);
    wr(1, A, 3, 2, 1); expect_wr("R7 old address gone", 1, OKAY, 1);
    wr(1, B, 3, 2, 1); expect_wr("R7 new address held", 1, EXOK, 0);
  endtask

  task automatic t_normal_read();
    rd(3, A, 3, 2, 0); expect_rd("R8", 3, OKAY);
    wr(3, A, 3, 2, 1); expect_wr("R8 no arm", 3, OKAY, 1);
    rd(2, B, 0, 2, 1);
    rd(3, B, 0, 2, 0);
    wr(2, B, 0, 2, 1); expect_wr("R8 no clear", 2, EXOK, 0);
  endtask

  task automatic t_too_big();
    rd(2, A, 3, 2, 1);
    rd(2, A, 63, 2, 1); expect_rd("R9 refused", 2, OKAY);
    wr(2, A, 63, 2, 1); expect_wr("R9 no reservation", 2, OKAY, 1);
    wr(2, A, 3, 2, 1); expect_wr("R9 earlier dropped", 2, OKAY, 1);
    rd(2, A, 31, 2, 1); expect_rd("R9 exact limit", 2, EXOK);
    wr(2, A, 31, 2, 1); expect_wr("R9 exact limit", 2, EXOK, 0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk); set_rd(3, A, 3, 2, 1); set_wr(1, A, 3, 2, 0);
    @(negedge clk); ar_valid = 0; ar_ready = 0; aw_valid = 0; aw_ready = 0;
    expect_rd("R10", 3, EXOK); expect_wr("R10", 1, OKAY, 0);
    wr(3, A, 3, 2, 1); expect_wr("R10 read survives", 3, EXOK, 0);
  endtask

  task automatic t_failed_no_clear();
    rd(0, A, 3, 2, 1);
    wr(1, A, 3, 2, 1); expect_wr("R11 fail", 1, OKAY, 1);
    wr(0, A, 3, 2, 1); expect_wr("R11 other kept", 0, EXOK, 0);
  endtask

  task automatic t_stall();
    rd(2, A, 3, 2, 1);
    @(negedge clk); set_wr(1, A, 3, 2, 0); aw_ready = 0;
    set_rd(2, B, 3, 2, 1); ar_ready = 0;
    @(negedge clk); aw_valid = 0; ar_valid = 0;
    check("R1 stalled wr no pulse", wr_rsp_vld, 0);
    check("R1 stalled rd no pulse", rd_rsp_vld, 0);
    wr(2, A, 3, 2, 1); expect_wr("R1 stall changed nothing", 2, EXOK, 0);
    @(negedge clk);
    check("R1 pulse lasts one cycle", wr_rsp_vld, 0);
  endtask

  task automatic t_reset_clears();
    rd(2, A, 3, 2, 1);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    t_reset_state();
    wr(2, A, 3, 2, 1); expect_wr("R12 reservation cleared", 2, OKAY, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_basic_pair();
    t_overlap();
    t_replace();
    t_normal_read();
    t_too_big();
    t_same_cycle();
    t_failed_no_clear();
    t_stall();
    t_reset_clears();
    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule